// File: doc/BRIEF.md
# Protection Region Bound Decoder

This block sits beside a bank of memory-protection entries. Every entry supplies a two-bit matching mode and an address register that holds a byte address divided by four. The block turns each entry's mode and register, plus the register of the entry below it, into an inclusive byte range. It then checks whether the first byte and the last byte of an incoming access fall inside that range.

For every entry the block returns two flags, registered one cycle after a valid request. The full flag means the whole access lies in the region. The partial flag means only one end of the access does. A permission stage downstream reads these flags in entry order. This block does not store the entries and does not resolve permissions.

The bounds are pure combinational logic on the entry inputs. A change to the register file therefore takes effect on the next request, with no extra latency.

Top module: `rgn_bound_chk`

## Requirements
- R1: While rst_ni is low, rsp_valid_o, rsp_full_o and rsp_part_o are all zero.
- R2: rsp_valid_o is high exactly in the cycle after a cycle with req_valid_i high. After a cycle without a request, both flag vectors are zero.
- R3: In mode 1 (top-of-range), the region starts at the previous entry's register shifted left by 2 and ends one byte below this entry's register shifted left by 2. Entry 0 uses 0 as its previous register.
- R4: If a mode-1 region's start is above its end, both bounds become 0, so the region is byte 0 only.
- R5: In mode 2, the region is the four bytes starting at the register shifted left by 2.
- R6: In mode 3, the region is naturally aligned. If the register ends in k one bits, the region has 2^(k+3) bytes. A register of all ones covers the whole address space.
- R7: An entry in mode 0 (off) never raises its full or partial flag.
- R8: The last byte is req_addr_i + size - 1. For an enabled entry, the full flag is set when both the first and last byte are inside the region. The partial flag is set when exactly one of them is inside.
- R9: A req_size_i of 0 is taken as AW/8 bytes. Sizes 1, 2, 4 and 8 are used as given.
- R10: The last-byte address wraps modulo 2^AW, and all bound comparisons are unsigned.
- R11: A new entry mode or register value is used by the very next request, including a request that directly follows one made with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | AW | Byte address of the access's first byte |
| req_size_i | input | 4 | Access size in bytes (0 means AW/8) |
| ent_mode_i | input | 2*N | Per-entry mode, entry i at bits [2i+1:2i] (0 off, 1 top-of-range, 2 four-byte, 3 aligned power of two) |
| ent_addr_i | input | AW*N | Per-entry address register (byte address divided by 4), entry i at bits [AW*i+AW-1:AW*i] |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_full_o | output | N | Per-entry flag: access fully inside the region |
| rsp_part_o | output | N | Per-entry flag: access partly inside the region |

## Verification
The assertions assume that req_size_i is 0, 1, 2, 4 or 8, and that the entry inputs hold known values whenever a request is made. The stimulus draws sizes only from that set and never leaves the entry vectors undriven. Entry registers and access addresses are drawn from a narrow window, so top-of-range, inverted and power-of-two regions land next to the accesses, including accesses that straddle a region edge. Directed cases also place an access at the top of the address space so that its last byte wraps to the bottom.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
  typedef enum logic [1:0] {
    RGN_OFF   = 2'd0,
    RGN_TOR   = 2'd1,
    RGN_NA4   = 2'd2,
    RGN_NAPOT = 2'd3
  } rgn_mode_e;
endpackage

// File: rtl/rgn_bound_dec.sv
module rgn_bound_dec
  import rgn_pkg::*;
#(
  parameter int AW = 32
) (
  input  rgn_mode_e         mode_i,
  input  logic [AW-1:0]     this_i,
  input  logic [AW-1:0]     prev_i,
  output logic [AW-1:0]     lo_o,
  output logic [AW-1:0]     hi_o
);
  logic [AW-1:0] base_b, prev_b, tor_hi, napot_a;

  assign base_b  = {this_i[AW-3:0], 2'b00};
  assign prev_b  = {prev_i[AW-3:0], 2'b00};
  assign tor_hi  = base_b - AW'(1);
  assign napot_a = base_b | AW'(3);

  always_comb begin
    lo_o = '0;
    hi_o = '0;
    unique case (mode_i)
      RGN_OFF: begin
        lo_o = '0;
        hi_o = '1;
      end
      RGN_TOR: begin
        // inverted range collapses to byte 0
        if (prev_b > tor_hi) begin
          lo_o = '0;
          hi_o = '0;
        end else begin
          lo_o = prev_b;
          hi_o = tor_hi;
        end
      end
      RGN_NA4: begin
        lo_o = base_b;
        hi_o = base_b + AW'(3);
      end
      RGN_NAPOT: begin
        // trailing ones select the size
        lo_o = napot_a & (napot_a + AW'(1));
        hi_o = napot_a | (napot_a + AW'(1));
      end
      default: begin
        lo_o = '0;
        hi_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/rgn_span_cmp.sv
module rgn_span_cmp #(
  parameter int AW = 32
) (
  input  logic          en_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  output logic          full_o,
  output logic          part_o
);
  logic in_first, in_last;

  assign in_first = (first_i >= lo_i) && (first_i <= hi_i);
  assign in_last  = (last_i  >= lo_i) && (last_i  <= hi_i);
  assign full_o   = en_i && in_first && in_last;
  assign part_o   = en_i && (in_first ^ in_last);
endmodule

// File: rtl/rgn_bound_chk.sv
module rgn_bound_chk
  import rgn_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [3:0]      req_size_i,
  input  logic [2*N-1:0]  ent_mode_i,
  input  logic [AW*N-1:0] ent_addr_i,
  output logic            rsp_valid_o,
  output logic [N-1:0]    rsp_full_o,
  output logic [N-1:0]    rsp_part_o
);
  localparam int WORD_B = AW / 8;

  logic [3:0]    size_eff;
  logic [AW-1:0] last_b;
  logic [N-1:0]  full_c, part_c;
  logic [AW-1:0] lo_w [N];
  logic [AW-1:0] hi_w [N];
  rgn_mode_e     mode_w [N];

  assign size_eff = (req_size_i == 4'd0) ? 4'(WORD_B) : req_size_i;
  assign last_b   = req_addr_i + AW'(size_eff) - AW'(1);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [AW-1:0] prev_r;
    assign mode_w[i] = rgn_mode_e'(ent_mode_i[2*i +: 2]);
    if (i == 0) begin : g_first
      assign prev_r = '0;
    end else begin : g_rest
      assign prev_r = ent_addr_i[AW*(i-1) +: AW];
    end

    rgn_bound_dec #(.AW(AW)) u_dec (
      .mode_i (mode_w[i]),
      .this_i (ent_addr_i[AW*i +: AW]),
      .prev_i (prev_r),
      .lo_o   (lo_w[i]),
      .hi_o   (hi_w[i])
    );

    rgn_span_cmp #(.AW(AW)) u_cmp (
      .en_i    (mode_w[i] != RGN_OFF),
      .lo_i    (lo_w[i]),
      .hi_i    (hi_w[i]),
      .first_i (req_addr_i),
      .last_i  (last_b),
      .full_o  (full_c[i]),
      .part_o  (part_c[i])
    );

    p_tor_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && mode_w[i] == RGN_TOR) |-> (lo_w[i] <= hi_w[i]));
    p_na4_span_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && mode_w[i] == RGN_NA4) |-> (hi_w[i] - lo_w[i] == AW'(3)));
    p_napot_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && mode_w[i] == RGN_NAPOT) |->
        ((((hi_w[i] - lo_w[i]) + AW'(1)) & (hi_w[i] - lo_w[i])) == '0 &&
         (lo_w[i] & (hi_w[i] - lo_w[i])) == '0));
    p_off_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && mode_w[i] == RGN_OFF) |=> (!rsp_full_o[i] && !rsp_part_o[i]));
    p_flag_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rsp_full_o[i] && rsp_part_o[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_full_o  <= '0;
      rsp_part_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_full_o  <= req_valid_i ? full_c : '0;
      rsp_part_o  <= req_valid_i ? part_c : '0;
    end
  end

  p_rsp_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && rsp_full_o == '0 && rsp_part_o == '0));
  p_size_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_size_i inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd8}));
endmodule

// File: tb/rgn_bound_chk_tb_top.sv
module rgn_bound_chk_tb_top;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam longint M = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_size = '0;
  logic [1:0] mode_m [N];
  logic [AW-1:0] reg_m [N];
  logic [2*N-1:0] ent_mode;
  logic [AW*N-1:0] ent_addr;
  logic rsp_valid;
  logic [N-1:0] rsp_full, rsp_part;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic exp_valid;
  logic [N-1:0] exp_full, exp_part;
  string exp_tag;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_mode[2*i +: 2]  = mode_m[i];
      ent_addr[AW*i +: AW] = reg_m[i];
    end
  end

  rgn_bound_chk #(.N(N), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .req_size_i(req_size),
    .ent_mode_i(ent_mode), .ent_addr_i(ent_addr),
    .rsp_valid_o(rsp_valid), .rsp_full_o(rsp_full), .rsp_part_o(rsp_part)
  );

  // behavioural expectation from the requirement text
  task automatic model(output logic [N-1:0] f, output logic [N-1:0] p);
    longint lo, hi, b, pb, a, first, last, sz;
    bit i1, i2;
    f = '0; p = '0;
    sz = (req_size == 0) ? (AW / 8) : longint'(req_size);          // R9
    first = longint'(req_addr);
    last = (first + sz - 1) & M;                                    // R10
    for (int i = 0; i < N; i++) begin
      b  = (longint'(reg_m[i]) * 4) & M;
      pb = (i == 0) ? 0 : (longint'(reg_m[i-1]) * 4) & M;
      lo = 0; hi = 0;
      case (mode_m[i])
        2'd1: begin                                                 // R3
          lo = pb; hi = (b - 1) & M;
          if (lo > hi) begin lo = 0; hi = 0; end                    // R4
        end
        2'd2: begin lo = b; hi = b + 3; end                         // R5
        2'd3: begin                                                 // R6
          a = b + 3;
          sz = 8;
          while (sz <= (M + 1) && (a & (sz / 2)) != 0 && sz < 64'h1_0000_0000) sz = sz * 2;
          if ((a & M) == M) begin lo = 0; hi = M; end
          else begin
            sz = 8;
            for (int k = 2; k < AW; k++) begin
              if (((a >> k) & 1) == 1) sz = sz * 2; else break;
            end
            lo = a - (a % sz); hi = lo + sz - 1;
          end
        end
        default: ;
      endcase
      if (mode_m[i] != 2'd0) begin                                  // R7
        i1 = (first >= lo) && (first <= hi);
        i2 = (last >= lo) && (last <= hi);
        f[i] = i1 && i2;                                            // R8
        p[i] = i1 ^ i2;
      end
    end
  endtask

  task automatic check_now();
    n_run++;
    if (rsp_valid !== exp_valid || rsp_full !== exp_full || rsp_part !== exp_part) begin
      n_fail++;
      $display("FAIL %s: got v=%b f=%b p=%b exp v=%b f=%b p=%b", exp_tag,
               rsp_valid, rsp_full, rsp_part, exp_valid, exp_full, exp_part);
    end
  endtask

  // drive at negedge, check one full cycle later
  task automatic step(input bit v, input logic [AW-1:0] ad, input logic [3:0] sz, input string tag);
    logic [N-1:0] f, p;
    req_valid = v; req_addr = ad; req_size = sz;
    #1;
    model(f, p);
    @(posedge clk);
    @(negedge clk);
    exp_valid = v;
    exp_full = v ? f : '0;
    exp_part = v ? p : '0;
    exp_tag = tag;
    check_now();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mode_m[i] = 2'd0; reg_m[i] = '0; end
    exp_valid = 0; exp_full = '0; exp_part = '0; exp_tag = "R1";
    repeat (3) @(negedge clk);
    check_now();                                      // R1 reset state
    req_valid = 1'b1; req_size = 4'd4;
    @(negedge clk);
    check_now();                                      // R1 request under reset ignored
    req_valid = 1'b0;
    rst_n = 1'b1;
    step(0, 32'h0, 4'd0, "R2");

    mode_m[0] = 2'd1; reg_m[0] = 32'h10;
    mode_m[1] = 2'd1; reg_m[1] = 32'h20;
    mode_m[2] = 2'd2; reg_m[2] = 32'h40;
    mode_m[3] = 2'd3; reg_m[3] = 32'h47;
    mode_m[4] = 2'd1; reg_m[4] = 32'h08;
    mode_m[5] = 2'd0; reg_m[5] = 32'h3FF;
    mode_m[6] = 2'd3; reg_m[6] = 32'hFFFF_FFFF;
    mode_m[7] = 2'd1; reg_m[7] = 32'h0;
    step(1, 32'h3C, 4'd4, "R3");
    step(1, 32'h3E, 4'd4, "R8");
    step(1, 32'h40, 4'd8, "R3");
    step(1, 32'h100, 4'd0, "R9");
    step(1, 32'h102, 4'd4, "R5");
    step(1, 32'h13C, 4'd4, "R6");
    step(1, 32'h13E, 4'd4, "R6");
    step(1, 32'h0, 4'd1, "R4");
    step(1, 32'h1, 4'd1, "R4");
    step(1, 32'hFFFF_FFFE, 4'd4, "R10");
    step(1, 32'hFFFF_FFFC, 4'd2, "R10");
    step(1, 32'h0FF0, 4'd8, "R7");
    step(0, 32'h3C, 4'd4, "R2");
    step(1, 32'h104, 4'd1, "R11");
    reg_m[2] = 32'h41;
    step(1, 32'h104, 4'd1, "R11");
    mode_m[2] = 2'd0;
    step(1, 32'h104, 4'd1, "R11");

    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < N; i++) begin
        mode_m[i] = 2'($urandom_range(0, 3));
        reg_m[i] = (($urandom_range(0, 7) == 0) ? ((32'h1 << $urandom_range(0, 6)) - 1)
                                                : 32'($urandom_range(0, 96)));
      end
      case ($urandom_range(0, 4))
        0: req_size = 4'd0;
        1: req_size = 4'd1;
        2: req_size = 4'd2;
        3: req_size = 4'd4;
        default: req_size = 4'd8;
      endcase
      step($urandom_range(0, 5) != 0, 32'($urandom_range(0, 400)), req_size, "R8");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule